// File: doc/BRIEF.md
# Counted I2C Master Transfer Sequencer

This block runs master-mode I2C transactions one byte at a time. Software programs a 16-bit control word, a byte count and a 10-bit target address. When it sets the start bit, the sequencer directs a byte-level bus engine through these steps: an address phase, then byte sends or byte receives, then an optional stop. The engine handles the bit timing. It reports back with a one-cycle done pulse and an acknowledge bit. Bytes to transmit enter on a valid/ready stream. Received bytes leave through a small buffer on a second valid/ready stream.

There are two modes. In counted mode a live copy of the count is decremented once per byte. When that copy reaches zero, the sequencer either issues a stop, or reports access-ready and drops master mode if no stop was requested. In repeat mode the count is ignored and data keeps moving until software writes the stop bit. A missing acknowledge at any phase sets a sticky flag and cancels a pending stop. A build option makes a control write that clears the enable bit wipe the whole controller, as older controller revisions do.

Back-pressure rules: a transmit byte is taken on a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` is only raised while the sequencer is idle in the data phase and may send. On the receive side, `rx_data` holds steady while `rx_valid` is high and `rx_ready` is low. When the buffer fills, the sequencer stops issuing receive commands.

Top module: `i2c_xfer_seq`

## Requirements
- R1: A control write stores only the bits of mask 0xCF87. Enable is bit 15, master bit 10, transmit bit 9, repeat bit 2, stop bit 1 and start bit 0. The start bit always reads back as 0.
- R2: A control write with enable, master and start all set, made while no engine command is outstanding, issues a START command. The command carries the stored 10-bit address, and `cmd_rd` equals the inverse of the written transmit bit. It also empties the receive buffer. Start without master or enable issues no command.
- R3: If the address phase is not acknowledged, `stat_nack` is set, the stop bit is cleared, no further command is issued and the current count is left unchanged.
- R4: In counted mode an acknowledged address loads the current count from the count register, and each completed byte decrements it. At zero with stop set, a STOP is issued. When it completes, the stop bit clears and the current count reloads.
- R5: In counted mode, reaching zero with stop clear sets `stat_ardy`, clears the master bit and returns to idle.
- R6: In repeat mode the count is ignored. Bytes keep flowing until the stop bit is written, and a STOP then follows.
- R7: Received bytes enter a buffer of RX_DEPTH entries (4 by default) and leave in arrival order on the rx stream. `stat_rrdy` is high while the buffer is not empty. No receive command is issued while it is full.
- R8: `tx_ready` (mirrored on `stat_xrdy`) is high only in the data phase of a transmit transfer. In counted mode it also requires a nonzero current count. An accepted byte is sent as the next command.
- R9: A data byte that is not acknowledged sets `stat_nack`, clears the stop bit, still decrements the count in counted mode, and ends the transfer without a STOP.
- R10: At most one engine command is outstanding. `cmd_valid` and the command fields hold steady until `eng_done`.
- R11: With LEGACY_DIS_RST set, a control write with enable clear resets the control word, count, address, current count, flags, sequencer state and receive buffer.
- R12: A write to the status-clear register clears `stat_nack` where data bit 1 is 1 and `stat_ardy` where data bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 count, 2 address, 3 status clear |
| cfg_wdata | input | 16 | Register write data |
| ctrl_o | output | 16 | Stored control word |
| cur_count | output | CW | Live byte count |
| stat_nack | output | 1 | Sticky no-acknowledge flag |
| stat_ardy | output | 1 | Sticky access-ready flag |
| stat_rrdy | output | 1 | Receive buffer holds data |
| stat_xrdy | output | 1 | Transmit byte can be taken |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Transmit byte accepted this cycle if valid |
| tx_data | input | 8 | Transmit byte |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Consumer takes the received byte |
| rx_data | output | 8 | Oldest received byte |
| cmd_valid | output | 1 | Engine command outstanding |
| cmd_op | output | 2 | 0 START, 1 SEND, 2 RECV, 3 STOP |
| cmd_addr | output | 10 | Target address for START |
| cmd_rd | output | 1 | Read direction for START |
| cmd_byte | output | 8 | Byte for SEND |
| eng_done | input | 1 | One-cycle completion of the outstanding command |
| eng_ack | input | 1 | Acknowledge seen for START or SEND |
| eng_rdata | input | 8 | Byte returned by RECV |

## Verification
A corrupted current count shows up at the port on the next clock. It also changes the command sequence: a STOP or an access-ready report comes one byte early or late, and that is visible within one engine round trip. A wrong sequencer state shows up as a missing or extra command on the engine port, or as `tx_ready` rising at the wrong moment. A stop bit that fails to clear, or a buffer that loses order, is caught when the control word is read back or the received bytes are drained right after the transfer.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3} bus_op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_RUN, ST_SEND, ST_RECV, ST_STOP} seq_state_e;
  typedef enum logic [1:0] {SEL_CTRL = 2'd0, SEL_COUNT = 2'd1, SEL_SADDR = 2'd2, SEL_STCLR = 2'd3} cfg_sel_e;
  localparam int CB_EN  = 15;
  localparam int CB_MST = 10;
  localparam int CB_TRX = 9;
  localparam int CB_RPT = 2;
  localparam int CB_STP = 1;
  localparam int CB_STT = 0;
  localparam logic [15:0] CTRL_KEEP = 16'hCF87;
endpackage

// File: rtl/iseq_cfg_regs.sv
module iseq_cfg_regs #(
  parameter int CW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_clr,
  input  logic          wr_count,
  input  logic          wr_saddr,
  input  logic [15:0]   wdata,
  output logic [CW-1:0] count_q,
  output logic [AW-1:0] saddr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      count_q <= '0;
      saddr_q <= '0;
    end else begin
      if (wr_count) count_q <= wdata[CW-1:0];
      if (wr_saddr) saddr_q <= wdata[AW-1:0];
    end
  end
endmodule

// File: rtl/iseq_rx_fifo.sv
module iseq_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic         rd_valid,
  output logic [W-1:0] rd_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [FW-1:0] fill;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full     = (fill == FW'(DEPTH));
  assign rd_valid = (fill != '0);
  assign rd_data  = mem[rp];
  assign do_push  = push && !full;
  assign do_pop   = pop && rd_valid;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      fill <= fill + FW'(1);
      else if (do_pop && !do_push) fill <= fill - FW'(1);
    end
  end
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2cseq_pkg::*;
#(
  parameter int CW             = 16,
  parameter int RX_DEPTH       = 4,
  parameter bit LEGACY_DIS_RST = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   ctrl_o,
  output logic [CW-1:0] cur_count,
  output logic          stat_nack,
  output logic          stat_ardy,
  output logic          stat_rrdy,
  output logic          stat_xrdy,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic [7:0]    tx_data,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [7:0]    rx_data,
  output logic          cmd_valid,
  output logic [1:0]    cmd_op,
  output logic [9:0]    cmd_addr,
  output logic          cmd_rd,
  output logic [7:0]    cmd_byte,
  input  logic          eng_done,
  input  logic          eng_ack,
  input  logic [7:0]    eng_rdata
);
  localparam int AW = 10;

  seq_state_e    state, state_n;
  logic [15:0]   ctrl_q, ctrl_n;
  logic [CW-1:0] cnt_q, cnt_n, count_q;
  logic [AW-1:0] saddr_q;
  logic          nack_q, nack_n, ardy_q, ardy_n, rd_q, rd_n;
  logic [7:0]    byte_q, byte_n;
  logic          wr_ctrl, soft_clr, start_go, run_tx_ok, cnt_zero;
  logic          push, flush, fifo_full;

  assign wr_ctrl  = cfg_wr && (cfg_sel == SEL_CTRL);
  assign soft_clr = LEGACY_DIS_RST && wr_ctrl && !cfg_wdata[CB_EN];
  assign start_go = wr_ctrl && cfg_wdata[CB_EN] && cfg_wdata[CB_MST] && cfg_wdata[CB_STT]
                    && ((state == ST_IDLE) || (state == ST_RUN));
  assign cnt_zero = (cnt_q == '0);
  assign run_tx_ok = (state == ST_RUN) && ctrl_q[CB_TRX]
                     && (ctrl_q[CB_RPT] ? !ctrl_q[CB_STP] : !cnt_zero);
  assign tx_ready  = run_tx_ok && !start_go && !soft_clr;

  iseq_cfg_regs #(.CW(CW), .AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .wr_count(cfg_wr && (cfg_sel == SEL_COUNT)),
    .wr_saddr(cfg_wr && (cfg_sel == SEL_SADDR)),
    .wdata(cfg_wdata), .count_q(count_q), .saddr_q(saddr_q)
  );

  iseq_rx_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush || soft_clr),
    .push(push), .push_data(eng_rdata), .pop(rx_ready),
    .full(fifo_full), .rd_valid(rx_valid), .rd_data(rx_data)
  );

  always_comb begin
    state_n = state;
    ctrl_n  = wr_ctrl ? ((cfg_wdata & CTRL_KEEP) & ~16'h0001) : ctrl_q;
    cnt_n   = cnt_q;
    nack_n  = nack_q;
    ardy_n  = ardy_q;
    if (cfg_wr && (cfg_sel == SEL_STCLR)) begin
      if (cfg_wdata[1]) nack_n = 1'b0;
      if (cfg_wdata[2]) ardy_n = 1'b0;
    end
    rd_n   = rd_q;
    byte_n = byte_q;
    push   = 1'b0;
    flush  = 1'b0;
    if (start_go) begin
      state_n = ST_ADDR;
      rd_n    = ~cfg_wdata[CB_TRX];
      flush   = 1'b1;
    end else begin
      unique case (state)
        ST_ADDR: if (eng_done) begin
          if (eng_ack) begin
            cnt_n   = count_q;
            state_n = ST_RUN;
          end else begin
            nack_n         = 1'b1;
            ctrl_n[CB_STP] = 1'b0;
            state_n        = ST_IDLE;
          end
        end
        ST_RUN: begin
          if (!ctrl_q[CB_RPT] && cnt_zero) begin
            if (ctrl_q[CB_STP]) state_n = ST_STOP;
            else begin
              ardy_n         = 1'b1;
              ctrl_n[CB_MST] = 1'b0;
              state_n        = ST_IDLE;
            end
          end else if (ctrl_q[CB_RPT] && ctrl_q[CB_STP]) begin
            state_n = ST_STOP;
          end else if (ctrl_q[CB_TRX]) begin
            if (tx_valid && tx_ready) begin
              byte_n  = tx_data;
              state_n = ST_SEND;
            end
          end else if (!fifo_full) begin
            state_n = ST_RECV;
          end
        end
        ST_SEND: if (eng_done) begin
          if (!ctrl_q[CB_RPT]) cnt_n = cnt_q - CW'(1);
          if (!eng_ack) begin
            nack_n         = 1'b1;
            ctrl_n[CB_STP] = 1'b0;
            state_n        = ST_IDLE;
          end else begin
            state_n = ST_RUN;
          end
        end
        ST_RECV: if (eng_done) begin
          push = 1'b1;
          if (!ctrl_q[CB_RPT]) cnt_n = cnt_q - CW'(1);
          state_n = ST_RUN;
        end
        ST_STOP: if (eng_done) begin
          ctrl_n[CB_STP] = 1'b0;
          cnt_n          = count_q;
          state_n        = ST_IDLE;
        end
        default: state_n = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      state  <= ST_IDLE;
      ctrl_q <= '0;
      cnt_q  <= '0;
      nack_q <= 1'b0;
      ardy_q <= 1'b0;
      rd_q   <= 1'b0;
      byte_q <= '0;
    end else begin
      state  <= state_n;
      ctrl_q <= ctrl_n;
      cnt_q  <= cnt_n;
      nack_q <= nack_n;
      ardy_q <= ardy_n;
      rd_q   <= rd_n;
      byte_q <= byte_n;
    end
  end

  always_comb begin
    unique case (state)
      ST_SEND: cmd_op = OP_SEND;
      ST_RECV: cmd_op = OP_RECV;
      ST_STOP: cmd_op = OP_STOP;
      default: cmd_op = OP_START;
    endcase
  end

  assign cmd_valid = (state == ST_ADDR) || (state == ST_SEND) || (state == ST_RECV) || (state == ST_STOP);
  assign cmd_addr  = saddr_q;
  assign cmd_rd    = rd_q;
  assign cmd_byte  = byte_q;
  assign ctrl_o    = ctrl_q;
  assign cur_count = cnt_q;
  assign stat_nack = nack_q;
  assign stat_ardy = ardy_q;
  assign stat_rrdy = rx_valid;
  assign stat_xrdy = tx_ready;
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [15:0] ctrl_o,
  input logic        stat_nack,
  input logic        stat_ardy,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [7:0]  rx_data,
  input logic        cmd_valid,
  input logic [1:0]  cmd_op,
  input logic [9:0]  cmd_addr,
  input logic        cmd_rd,
  input logic [7:0]  cmd_byte,
  input logic        eng_done
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !eng_done && !cfg_wr) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)
                                             && $stable(cmd_rd) && $stable(cmd_byte))); // R10
  AST_TX_TO_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (cmd_valid && cmd_op == 2'd1 && cmd_byte == $past(tx_data))); // R8
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !cfg_wr) |=> (rx_valid && $stable(rx_data))); // R7
  AST_NACK_DROPS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_nack) |-> !ctrl_o[1]); // R9
  AST_ARDY_DROPS_MST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ardy) |-> !ctrl_o[10]); // R5
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .ctrl_o(ctrl_o),
  .stat_nack(stat_nack), .stat_ardy(stat_ardy),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .cmd_rd(cmd_rd), .cmd_byte(cmd_byte), .eng_done(eng_done)
);

// File: tb/i2c_xfer_seq_tb.sv
module i2c_xfer_seq_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] ctrl_o;
  logic [15:0] cur_count;
  logic        stat_nack, stat_ardy, stat_rrdy, stat_xrdy;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b0;
  logic [7:0]  rx_data;
  logic        cmd_valid, cmd_rd;
  logic [1:0]  cmd_op;
  logic [9:0]  cmd_addr;
  logic [7:0]  cmd_byte;
  logic        eng_done = 1'b0;
  logic        eng_ack = 1'b0;
  logic [7:0]  eng_rdata = '0;

  int checks = 0;
  int fails  = 0;

  // engine model state and command log
  logic [1:0] op_log   [64];
  logic [9:0] addr_log [64];
  logic       rd_log   [64];
  logic [7:0] byte_log [64];
  int         n_ops = 0;
  int         send_idx = 0;
  int         nack_send = -1;
  bit         nack_addr = 1'b0;
  logic [7:0] rx_next = 8'hA0;
  bit         eng_busy = 1'b0;
  int         eng_tmr = 0;

  always #2.5 clk = ~clk;

  i2c_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ctrl_o(ctrl_o), .cur_count(cur_count), .stat_nack(stat_nack), .stat_ardy(stat_ardy),
    .stat_rrdy(stat_rrdy), .stat_xrdy(stat_xrdy), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_rd(cmd_rd),
    .cmd_byte(cmd_byte), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
  );

  always @(negedge clk) begin
    if (eng_done) begin
      eng_done = 1'b0;
    end else if (eng_busy) begin
      if (eng_tmr == 0) begin
        eng_busy = 1'b0;
        eng_done = 1'b1;
        eng_ack  = 1'b1;
        if (cmd_op == 2'd0) eng_ack = !nack_addr;
        if (cmd_op == 2'd1) begin
          eng_ack  = (send_idx != nack_send);
          send_idx = send_idx + 1;
        end
        if (cmd_op == 2'd2) begin
          eng_rdata = rx_next;
          rx_next   = rx_next + 8'd1;
        end
        if (n_ops < 64) begin
          op_log[n_ops]   = cmd_op;
          addr_log[n_ops] = cmd_addr;
          rd_log[n_ops]   = cmd_rd;
          byte_log[n_ops] = cmd_byte;
          n_ops = n_ops + 1;
        end
      end else begin
        eng_tmr = eng_tmr - 1;
      end
    end else if (cmd_valid && rst_n) begin
      eng_busy = 1'b1;
      eng_tmr  = 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk);
  endtask

  task automatic clr_log();
    n_ops = 0; send_idx = 0; rx_next = 8'hA0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    #0.5;
    while (!tx_ready) begin
      @(negedge clk);
      #0.5;
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop_rx(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, {31'd0, rx_valid}, 32'd1);
    chk(req, {24'd0, rx_data}, {24'd0, exp});
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset cmd_valid", {31'd0, cmd_valid}, 0);
    chk("R11 reset ctrl", {16'd0, ctrl_o}, 0);
    chk("R11 reset count", {16'd0, cur_count}, 0);
    chk("R11 reset flags", {28'd0, stat_nack, stat_ardy, stat_rrdy, stat_xrdy}, 0);
  endtask

  task automatic t_mask_no_master();
    clr_log();
    cfg(2'd0, 16'hFBFF);
    settle();
    chk("R1 masked ctrl, start cleared", {16'd0, ctrl_o}, 32'hCB86);
    chk("R2 no command without master", n_ops, 0);
    chk("R2 cmd_valid idle", {31'd0, cmd_valid}, 0);
  endtask

  task automatic t_counted_tx_stop();
    clr_log();
    cfg(2'd1, 16'd3);
    cfg(2'd2, 16'h02A5);
    cfg(2'd0, 16'h8603);
    repeat (10) @(negedge clk);
    chk("R8 tx_ready in data phase", {31'd0, tx_ready}, 1);
    chk("R8 xrdy mirrors", {31'd0, stat_xrdy}, 1);
    push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
    settle();
    chk("R10 one entry per command", n_ops, 5);
    chk("R2 START op", {30'd0, op_log[0]}, 0);
    chk("R2 START addr", {22'd0, addr_log[0]}, 32'h2A5);
    chk("R2 START write dir", {31'd0, rd_log[0]}, 0);
    chk("R8 send 1", {22'd0, op_log[1], byte_log[1]}, {22'd0, 2'd1, 8'h11});
    chk("R8 send 2", {22'd0, op_log[2], byte_log[2]}, {22'd0, 2'd1, 8'h22});
    chk("R8 send 3", {22'd0, op_log[3], byte_log[3]}, {22'd0, 2'd1, 8'h33});
    chk("R4 STOP at zero", {30'd0, op_log[4]}, 3);
    chk("R4 count reloads", {16'd0, cur_count}, 3);
    chk("R4 stop bit cleared", {16'd0, ctrl_o}, 32'h8600);
    chk("R8 tx_ready low when done", {31'd0, tx_ready}, 0);
  endtask

  task automatic t_counted_rx_ardy();
    clr_log();
    cfg(2'd1, 16'd2);
    cfg(2'd0, 16'h8401);
    settle();
    chk("R2 read dir", {31'd0, rd_log[0]}, 1);
    chk("R5 commands", n_ops, 3);
    chk("R7 recv ops", {30'd0, op_log[2]}, 2);
    chk("R5 ardy set", {31'd0, stat_ardy}, 1);
    chk("R5 master cleared", {16'd0, ctrl_o}, 32'h8000);
    chk("R4 count at zero", {16'd0, cur_count}, 0);
    chk("R7 rrdy", {31'd0, stat_rrdy}, 1);
    pop_rx("R7 byte 0", 8'hA0);
    pop_rx("R7 byte 1", 8'hA1);
    @(negedge clk);
    chk("R7 empty", {31'd0, rx_valid}, 0);
  endtask

  task automatic t_addr_nack();
    clr_log();
    nack_addr = 1'b1;
    cfg(2'd1, 16'd7);
    cfg(2'd0, 16'h8603);
    settle();
    nack_addr = 1'b0;
    chk("R3 only START", n_ops, 1);
    chk("R3 nack flag", {31'd0, stat_nack}, 1);
    chk("R3 stop cleared", {16'd0, ctrl_o}, 32'h8600);
    chk("R3 count not loaded", {16'd0, cur_count}, 0);
    chk("R3 tx_ready low", {31'd0, tx_ready}, 0);
    cfg(2'd3, 16'h0006);
    @(negedge clk);
    chk("R12 nack cleared", {31'd0, stat_nack}, 0);
    chk("R12 ardy cleared", {31'd0, stat_ardy}, 0);
  endtask

  task automatic t_data_nack();
    clr_log();
    nack_send = 1;
    cfg(2'd1, 16'd4);
    cfg(2'd0, 16'h8603);
    push_tx(8'h51); push_tx(8'h52);
    settle();
    nack_send = -1;
    chk("R9 no STOP", n_ops, 3);
    chk("R9 last op SEND", {30'd0, op_log[2]}, 1);
    chk("R9 nack flag", {31'd0, stat_nack}, 1);
    chk("R9 stop cleared", {16'd0, ctrl_o}, 32'h8600);
    chk("R9 count decremented", {16'd0, cur_count}, 2);
    chk("R9 tx_ready low", {31'd0, tx_ready}, 0);
    cfg(2'd3, 16'h0002);
  endtask

  task automatic t_repeat_rx();
    clr_log();
    cfg(2'd1, 16'd1);
    cfg(2'd0, 16'h8405);
    settle();
    chk("R7 stalls when full", n_ops, 5);
    chk("R6 recv beyond count", {30'd0, op_log[4]}, 2);
    chk("R7 rrdy full", {31'd0, stat_rrdy}, 1);
    cfg(2'd0, 16'h8406);
    settle();
    chk("R6 stop issued", n_ops, 6);
    chk("R6 STOP op", {30'd0, op_log[5]}, 3);
    chk("R6 stop cleared", {16'd0, ctrl_o}, 32'h8404);
    pop_rx("R7 order 0", 8'hA0);
    pop_rx("R7 order 1", 8'hA1);
    pop_rx("R7 order 2", 8'hA2);
    pop_rx("R7 order 3", 8'hA3);
  endtask

  task automatic t_repeat_tx();
    clr_log();
    cfg(2'd1, 16'd0);
    cfg(2'd0, 16'h8605);
    repeat (10) @(negedge clk);
    chk("R6 tx_ready with zero count", {31'd0, tx_ready}, 1);
    for (int i = 0; i < 5; i++) push_tx(8'h61 + 8'(i));
    settle();
    chk("R6 five sends", n_ops, 6);
    chk("R6 last byte", {24'd0, byte_log[5]}, 32'h65);
    chk("R6 no ardy", {31'd0, stat_ardy}, 0);
    chk("R8 still ready", {31'd0, stat_xrdy}, 1);
    cfg(2'd0, 16'h8606);
    settle();
    chk("R6 STOP", {30'd0, op_log[6]}, 3);
    chk("R8 ready drops", {31'd0, tx_ready}, 0);
  endtask

  task automatic t_legacy_reset();
    clr_log();
    cfg(2'd1, 16'd0);
    cfg(2'd0, 16'h8401);
    settle();
    chk("R5 ardy at zero count", {31'd0, stat_ardy}, 1);
    cfg(2'd1, 16'd5);
    cfg(2'd2, 16'h0155);
    cfg(2'd0, 16'h0000);
    @(negedge clk);
    chk("R11 ardy wiped", {31'd0, stat_ardy}, 0);
    chk("R11 ctrl wiped", {16'd0, ctrl_o}, 0);
    clr_log();
    cfg(2'd0, 16'h8603);
    settle();
    chk("R11 count wiped", n_ops, 2);
    chk("R11 addr wiped", {22'd0, addr_log[0]}, 0);
    chk("R11 immediate STOP", {30'd0, op_log[1]}, 3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_no_master();
    t_counted_tx_stop();
    t_counted_rx_ardy();
    t_addr_nack();
    t_data_nack();
    t_repeat_rx();
    t_repeat_tx();
    t_legacy_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule